// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate with Rounding

This block is a one-cycle signed fractional multiply-accumulate datapath. Both operands are two's-complement fractions with one sign bit, covering -1 up to just below +1. Every clock, the block multiplies the two operands into a double-width product. A two-bit command then either loads that product into the accumulator, adds it, subtracts it, or leaves the accumulator unchanged. The accumulator is wider than the product by a set of guard bits, so long sums can grow past the product range without wrapping.

A separate store strobe reads the accumulator and turns it back into an operand-width word. It first rounds the value in one of three modes: truncate (floor), round half toward positive, or convergent (ties to even). It then clamps the result to the most positive or most negative word. A flag reports when that clamp was applied. A sticky flag reports that the guard bits held significant data when a store happened. An optional arithmetic right shift of the product by a fixed amount lets a long sum stay in range without relying on the guard bits.

The store strobe is independent of the command, so a sum can be read out while the next sum is already being started.

Top module: `fxmac_round`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `q`, `q_valid`, `q_sat` and `ovf` are all 0 and the accumulator holds 0.
- R2: Command `op` = 2'b01 (load) replaces the accumulator with the current product. The old contents have no effect on the new sum.
- R3: Command `op` = 2'b10 (add) adds the current product to the accumulator. The sum wraps modulo 2^(2*DW+GW) in the accumulator.
- R4: Command `op` = 2'b11 (subtract) subtracts the current product from the accumulator.
- R5: Command `op` = 2'b00 (hold) leaves the accumulator unchanged, whatever the operands are.
- R6: Setting `store` in a cycle gives `q_valid` = 1 in the next cycle. `q` then reflects the accumulator as it stood before that cycle's command took effect. Without `store`, `q_valid` is 0 in the next cycle.
- R7: With `rmode` = 2'b00 or 2'b11 (truncate), the result is floor(acc / 2^(DW-1)). The kept field is accumulator bits [2*DW-2 : DW-1].
- R8: With `rmode` = 2'b01 (nearest), the result is floor(acc / 2^(DW-1)) plus one when the discarded fraction is one half or more.
- R9: With `rmode` = 2'b10 (convergent), the result adds one when the discarded fraction is above one half. At exactly one half it adds the kept LSB, so the stored word ends up even.
- R10: A rounded result above 2^(DW-1)-1 or below -2^(DW-1) is clamped to that bound, with `q_sat` = 1. Otherwise `q_sat` = 0. The product (-1)*(-1) stored alone clamps to the maximum.
- R11: `ovf` becomes 1 after a store whose accumulator lies outside [-2^(2*DW-1), 2^(2*DW-1)-1], meaning its guard bits are not a sign extension. `ovf` stays 1 until a load command clears it. If a load and such a store fall in the same cycle, the flag is set.
- R12: With `pshift` = 1, the product is shifted arithmetically right by `PRE_SHIFT` (default 1) bits before it enters the adder. With `pshift` = 0, the product enters unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Accumulator command: 00 hold, 01 load, 10 add, 11 subtract |
| a | input | DW | First fractional operand |
| b | input | DW | Second fractional operand |
| store | input | 1 | Round, clamp and register the accumulator |
| rmode | input | 2 | Rounding: 00 truncate, 01 nearest, 10 convergent, 11 truncate |
| pshift | input | 1 | Shift the product right before the adder |
| q | output | DW | Rounded and clamped word |
| q_valid | output | 1 | `q` was written in the previous cycle |
| q_sat | output | 1 | The last stored word was clamped |
| ovf | output | 1 | Sticky guard-bit overflow flag |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a store with a command that changes the accumulator: the stored word must come from the sum before the update, not after. The second pair is a load with an overflowing store: the sticky flag must end up set, not cleared. Both pairs are provoked by a long pseudo-random stream of commands and stores in a small configuration, and by a directed sequence that drives the sum past the product range and then loads while storing. The results are judged against an arithmetic model in the bench that keeps the pre-update sum for every store.

// File: rtl/fxmac_pkg.sv
`timescale 1ns/1ps
package fxmac_pkg;

    localparam int MAC_DW = 24;
    localparam int MAC_GW = 8;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_LOAD = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC = 2'b00,
        RND_NEAR  = 2'b01,
        RND_CONV  = 2'b10,
        RND_TRUNC2 = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        mac_op_e   op;
        logic      store;
        rnd_mode_e rmode;
        logic      pshift;
    } mac_cmd_t;

    // Increment applied to the floored field, given the half bit, any lower bits and the kept LSB
    function automatic logic round_inc(input rnd_mode_e m, input logic half,
                                       input logic below, input logic lsb);
        logic r;
        case (m)
            RND_NEAR: r = half;
            RND_CONV: r = half & (below | lsb);
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fxmac_mul.sv
`timescale 1ns/1ps
module fxmac_mul #(
    parameter int DW = 24,
    parameter int GW = 8,
    parameter int PRE_SHIFT = 1,
    localparam int PW = 2 * DW,
    localparam int AW = PW + GW
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic                 pshift,
    output logic signed [AW-1:0] prod_ext
);
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_wide;

    always_comb begin
        prod      = a * b;
        prod_wide = {{GW{prod[PW-1]}}, prod};
    end

    generate
        if (PRE_SHIFT > 0) begin : g_shift
            always_comb prod_ext = pshift ? (prod_wide >>> PRE_SHIFT) : prod_wide;
        end else begin : g_noshift
            logic unused_ps;
            always_comb begin
                unused_ps = pshift;
                prod_ext  = prod_wide;
            end
        end
    endgenerate

endmodule

// File: rtl/fxmac_acc.sv
`timescale 1ns/1ps
module fxmac_acc
    import fxmac_pkg::*;
#(
    parameter int DW = 24,
    parameter int GW = 8,
    localparam int PW = 2 * DW,
    localparam int AW = PW + GW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mac_op_e              op,
    input  logic                 store,
    input  logic signed [AW-1:0] prod_ext,
    output logic signed [AW-1:0] acc,
    output logic                 ovf
);
    logic signed [AW-1:0] acc_n;
    logic [GW:0]          top_bits;
    logic                 guard_bad;

    always_comb begin
        top_bits  = acc[AW-1:PW-1];
        guard_bad = ~((&top_bits) | ~(|top_bits));
    end

    always_comb begin
        case (op)
            OP_LOAD: acc_n = prod_ext;
            OP_ADD:  acc_n = acc + prod_ext;
            OP_SUB:  acc_n = acc - prod_ext;
            default: acc_n = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else begin
            acc <= acc_n;
            if (store && guard_bad)
                ovf <= 1'b1;
            else if (op == OP_LOAD)
                ovf <= 1'b0;
        end
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(acc)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && op != OP_LOAD) |=> ovf); // R11

    AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD && !store) |=> !ovf); // R11

endmodule

// File: rtl/fxmac_store.sv
`timescale 1ns/1ps
module fxmac_store
    import fxmac_pkg::*;
#(
    parameter int DW = 24,
    parameter int GW = 8,
    localparam int PW = 2 * DW,
    localparam int AW = PW + GW,
    localparam int FB = DW - 1,
    localparam int RW = AW - FB + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 store,
    input  rnd_mode_e            rmode,
    input  logic signed [AW-1:0] acc,
    output logic        [DW-1:0] q,
    output logic                 q_valid,
    output logic                 q_sat
);
    localparam logic signed [RW-1:0] MAXV = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [RW-1:0] MINV = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] QMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] QMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [RW-1:0] floor_v;
    logic signed [RW-1:0] rounded;
    logic                 inc;
    logic                 hi_clip;
    logic                 lo_clip;
    logic [DW-1:0]        q_n;

    always_comb begin
        floor_v = {acc[AW-1], acc[AW-1:FB]};
        inc     = round_inc(rmode, acc[FB-1], |acc[FB-2:0], acc[FB]);
        rounded = floor_v + {{(RW-1){1'b0}}, inc};
        hi_clip = rounded > MAXV;
        lo_clip = rounded < MINV;
        if (hi_clip)      q_n = QMAX;
        else if (lo_clip) q_n = QMIN;
        else              q_n = rounded[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
            q_sat   <= 1'b0;
        end else begin
            q_valid <= store;
            if (store) begin
                q     <= q_n;
                q_sat <= hi_clip | lo_clip;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        store |=> q_valid); // R6

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !store |=> !q_valid); // R6

    AST_SAT_EXTREME: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_sat) |-> (q == QMAX || q == QMIN)); // R10

    AST_TRUNC_NO_INC: assert property (@(posedge clk) disable iff (rst)
        (store && (rmode == RND_TRUNC || rmode == RND_TRUNC2)) |-> !inc); // R7

endmodule

// File: rtl/fxmac_round.sv
`timescale 1ns/1ps
module fxmac_round
    import fxmac_pkg::*;
#(
    parameter int DW = MAC_DW,
    parameter int GW = MAC_GW,
    parameter int PRE_SHIFT = 1,
    localparam int AW = 2 * DW + GW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          store,
    input  logic [1:0]    rmode,
    input  logic          pshift,
    output logic [DW-1:0] q,
    output logic          q_valid,
    output logic          q_sat,
    output logic          ovf
);
    mac_cmd_t             cmd;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] acc;

    always_comb begin
        cmd.op     = mac_op_e'(op);
        cmd.store  = store;
        cmd.rmode  = rnd_mode_e'(rmode);
        cmd.pshift = pshift;
    end

    fxmac_mul #(.DW(DW), .GW(GW), .PRE_SHIFT(PRE_SHIFT)) u_mul (
        .a        (signed'(a)),
        .b        (signed'(b)),
        .pshift   (cmd.pshift),
        .prod_ext (prod_ext)
    );

    fxmac_acc #(.DW(DW), .GW(GW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .op       (cmd.op),
        .store    (cmd.store),
        .prod_ext (prod_ext),
        .acc      (acc),
        .ovf      (ovf)
    );

    fxmac_store #(.DW(DW), .GW(GW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .store   (cmd.store),
        .rmode   (cmd.rmode),
        .acc     (acc),
        .q       (q),
        .q_valid (q_valid),
        .q_sat   (q_sat)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!q_valid && !q_sat && !ovf)); // R1

endmodule

// File: tb/sim_fxmac_round.sv
`timescale 1ns/1ps
module sim_fxmac_round;
    localparam int DW = 4;
    localparam int GW = 2;
    localparam int AW = 2 * DW + GW;
    localparam int FB = DW - 1;
    localparam longint HALF = longint'(1) <<< (FB - 1);
    localparam longint QMAXL = (longint'(1) <<< (DW - 1)) - 1;
    localparam longint QMINL = -(longint'(1) <<< (DW - 1));
    localparam longint PMAX = (longint'(1) <<< (2 * DW - 1)) - 1;
    localparam longint PMIN = -(longint'(1) <<< (2 * DW - 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    op = 2'b00;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic          store = 1'b0;
    logic [1:0]    rmode = 2'b00;
    logic          pshift = 1'b0;
    logic [DW-1:0] q;
    logic          q_valid;
    logic          q_sat;
    logic          ovf;

    int     total = 0;
    int     bad = 0;
    bit     done = 1'b0;
    longint m = 0;
    bit     ovf_m = 1'b0;

    always #2.5 clk = ~clk;

    fxmac_round #(.DW(DW), .GW(GW), .PRE_SHIFT(1)) u0 (
        .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .store(store),
        .rmode(rmode), .pshift(pshift), .q(q), .q_valid(q_valid),
        .q_sat(q_sat), .ovf(ovf)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint wrap_acc(input longint v);
        return (v <<< (64 - AW)) >>> (64 - AW);
    endfunction

    // One cycle: drive at the falling edge, compare after the next rising edge
    task automatic step(input logic [1:0] op_i, input int a_i, input int b_i,
                        input logic st_i, input logic [1:0] rm_i, input logic ps_i,
                        input string tag);
        longint p, fl, rem, r, eq;
        bit es, eo;
        op = op_i; a = a_i[DW-1:0]; b = b_i[DW-1:0];
        store = st_i; rmode = rm_i; pshift = ps_i;
        p = longint'(a_i) * longint'(b_i);
        if (ps_i) p = p >>> 1;
        fl  = m >>> FB;
        rem = m - (fl <<< FB);
        case (rm_i)
            2'b01: r = fl + longint'(rem >= HALF);
            2'b10: begin
                if (rem > HALF)       r = fl + 1;
                else if (rem == HALF) r = fl + (fl & 1);
                else                  r = fl;
            end
            default: r = fl;
        endcase
        es = (r > QMAXL) || (r < QMINL);
        eq = (r > QMAXL) ? QMAXL : ((r < QMINL) ? QMINL : r);
        eo = ovf_m;
        if (st_i && (m > PMAX || m < PMIN)) eo = 1'b1;
        else if (op_i == 2'b01)             eo = 1'b0;
        case (op_i)
            2'b01: m = wrap_acc(p);
            2'b10: m = wrap_acc(m + p);
            2'b11: m = wrap_acc(m - p);
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(q_valid === st_i, "R6 q_valid", longint'(q_valid), longint'(st_i));
        if (st_i) begin
            check(longint'($signed(q)) == eq, tag, longint'($signed(q)), eq);
            check(q_sat === es, "R10 q_sat", longint'(q_sat), longint'(es));
        end
        check(ovf === eo, "R11 ovf", longint'(ovf), longint'(eo));
        ovf_m = eo;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset
        check(q_valid === 1'b0 && q_sat === 1'b0 && ovf === 1'b0, "R1 flags", longint'({q_valid, q_sat, ovf}), 0);
        check(q === '0, "R1 q", longint'(q), 0);
        rst = 1'b0;
        // R1: accumulator starts at zero
        step(2'b00, 3, 5, 1'b1, 2'b00, 1'b0, "R1 acc");

        // Exhaustive single products through every rounding mode, both shift settings
        for (int rm = 0; rm < 3; rm++) begin
            for (int ps = 0; ps < 2; ps++) begin
                for (int x = -8; x < 8; x++) begin
                    for (int y = -8; y < 8; y++) begin
                        step(2'b01, x, y, 1'b0, 2'(rm), 1'(ps), "R2 load");
                        // R5: hold with unrelated operands must not move the sum
                        if (rm == 0)      step(2'b00, 7, 7, 1'b1, 2'(rm), 1'(ps), ps ? "R12 R7 trunc" : "R7 trunc");
                        else if (rm == 1) step(2'b00, -8, 7, 1'b1, 2'(rm), 1'(ps), ps ? "R12 R8 nearest" : "R8 nearest");
                        else              step(2'b00, 5, -3, 1'b1, 2'(rm), 1'(ps), ps ? "R12 R9 convergent" : "R9 convergent");
                    end
                end
            end
        end

        // R10: (-1)*(-1) clamps to the maximum
        step(2'b01, -8, -8, 1'b0, 2'b00, 1'b0, "R2 load");
        step(2'b00, 0, 0, 1'b1, 2'b10, 1'b0, "R10 clamp max");
        // R3 and R11: grow the sum past the product range, then load while storing
        step(2'b10, -8, -8, 1'b0, 2'b00, 1'b0, "R3 add");
        step(2'b10, -8, -8, 1'b1, 2'b01, 1'b0, "R3 add");
        step(2'b01, 1, 1, 1'b1, 2'b00, 1'b0, "R11 load with store");
        step(2'b00, 0, 0, 1'b0, 2'b00, 1'b0, "R11 sticky");
        step(2'b01, 1, 1, 1'b0, 2'b00, 1'b0, "R11 cleared by load");
        // R4 and R10: drive negative past the minimum
        step(2'b11, 7, 7, 1'b0, 2'b00, 1'b0, "R4 sub");
        step(2'b11, 7, 7, 1'b0, 2'b00, 1'b0, "R4 sub");
        step(2'b00, 0, 0, 1'b1, 2'b01, 1'b0, "R10 clamp min");

        // Pseudo-random mix of every command with stores in the same cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] o;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            o = lfsr[1:0];
            step(o, int'($signed(lfsr[5:2])), int'($signed(lfsr[9:6])), lfsr[10],
                 (lfsr[12:11] == 2'b11) ? 2'b10 : lfsr[12:11], lfsr[13],
                 (o == 2'b10) ? "R3 add+store" : (o == 2'b11) ? "R4 sub+store" :
                 (o == 2'b01) ? "R2 load+store" : "R5 hold+store");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule